// File: doc/BRIEF.md
# Receive Byte Queue with Programmable Trigger Threshold

This block buffers bytes coming out of a serial receiver on their way to a host. The receiver pushes each byte it assembles, and the host pops bytes from the head. An 8-bit control byte, written through a single write strobe, turns queuing on or off, empties the queue on request, and picks one of four fill thresholds. A trigger output rises once the fill reaches the chosen threshold, and it feeds the data-ready interrupt logic.

When queuing is off, the same storage acts as a one-byte holding register and the trigger fires on any stored byte. The head byte is visible on the read data port in the cycle it becomes available, so a pop consumes the byte the host has already seen. A sticky overrun flag records bytes that were dropped because no room was left.

Top module: `uart_rxq`

## Requirements
- R1: After reset, queuing is off, the threshold code is 00, the fill count is 0, empty is 1, and full, trigger and overrun are 0. The read data port shows 0.
- R2: A control write updates the threshold code (bits 7:6) and acts on the flush request (bit 1) only when bit 0 of the same write is 1. Otherwise bit 1 has no effect and the stored contents stay as they are.
- R3: A control write with bits 0 and 1 both set empties the queue and clears overrun at that clock edge. A push in the same cycle is dropped and does not set overrun. The flush request is a one-cycle action: later writes with bit 1 clear do not empty the queue.
- R4: With queuing on, threshold code 00 selects 1 byte, 01 selects 4, 10 selects 8 and 11 selects 14. The trigger is 1 exactly when the fill count is at least the selected threshold.
- R5: With queuing on, the queue holds up to 16 bytes in arrival order, and full is 1 when 16 bytes are stored.
- R6: A push while full with no pop in the same cycle is dropped, leaves the count and the head unchanged, and sets overrun. Overrun stays set until a flush or reset. A push together with a pop while full is accepted.
- R7: A pop while empty leaves the count at 0, and the read data port keeps showing the byte that was last popped.
- R8: With queuing off, capacity is one byte (full once one byte is held) and the threshold is 1, whatever the threshold code.
- R9: A control write that changes the value of bit 0 empties the queue and clears overrun, as a flush does.
- R10: While not empty, the read data port shows the oldest stored byte combinationally, and a pop advances it to the next byte at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push a received byte |
| push_data_i | input | WIDTH | Byte to push |
| pop_i | input | 1 | Host pops the head byte |
| cfg_we_i | input | 1 | Control byte write strobe |
| cfg_wdata_i | input | 8 | Control byte: bit 0 queue on, bit 1 flush, bits 7:6 threshold code |
| rd_data_o | output | WIDTH | Head byte, or last popped byte when empty |
| empty_o | output | 1 | No byte stored |
| full_o | output | 1 | Fill count equals current capacity |
| count_o | output | $clog2(DEPTH+1) | Fill count |
| trig_o | output | 1 | Fill count at or above the threshold |
| overrun_o | output | 1 | Sticky flag for a dropped push |

## Verification
The bench builds the block with the default 8-bit width, 16-entry depth and threshold set 1/4/8/14, and it selects the storage variant with resettable entries. At this depth, sixteen pushes reach the full boundary and the overrun case, and the 14-byte threshold falls two entries below full. All four threshold codes can therefore be exercised against both edges of the count. The one-byte disabled mode, flushes that collide with pushes, and enable toggles that empty the queue are covered by a vector table. Directed fill and drain runs check the ordering against a queue model kept in the bench.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

   typedef enum logic [1:0] {
      TRIG_SEL_A = 2'b00,
      TRIG_SEL_B = 2'b01,
      TRIG_SEL_C = 2'b10,
      TRIG_SEL_D = 2'b11
   } trig_sel_e;

   typedef struct packed {
      logic      en;
      trig_sel_e sel;
   } rxq_cfg_t;

endpackage

// File: rtl/uart_rxq_ctl.sv
module uart_rxq_ctl
   import uart_rxq_pkg::*;
#(
   parameter int EN_BIT    = 0,
   parameter int FLUSH_BIT = 1,
   parameter int SEL_LSB   = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we_i,
   input  logic [7:0] wdata_i,
   output rxq_cfg_t   cfg_o,
   output logic       flush_o
);

   if (EN_BIT < 0 || EN_BIT > 7 || FLUSH_BIT < 0 || FLUSH_BIT > 7 ||
       SEL_LSB < 0 || SEL_LSB > 6) begin : g_bad_bits
      $error("uart_rxq_ctl: control bit position out of range");
   end

   rxq_cfg_t cfg_q;
   logic     wr_on;
   logic     unused_cfg;

   assign unused_cfg = ^wdata_i;
   assign wr_on      = we_i & wdata_i[EN_BIT];
   assign flush_o    = we_i & ((wr_on & wdata_i[FLUSH_BIT]) | (wdata_i[EN_BIT] != cfg_q.en));
   assign cfg_o      = cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q.en  <= 1'b0;
         cfg_q.sel <= TRIG_SEL_A;
      end else if (we_i) begin
         cfg_q.en <= wdata_i[EN_BIT];
         if (wr_on) cfg_q.sel <= trig_sel_e'(wdata_i[SEL_LSB +: 2]);
      end
   end

   // R2: threshold code is held across a write whose enable bit is clear
   assert_sel_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && !wdata_i[EN_BIT]) |=> $stable(cfg_o.sel));

endmodule

// File: rtl/uart_rxq_trig.sv
module uart_rxq_trig
   import uart_rxq_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CW    = 5,
   parameter int LVL_A = 1,
   parameter int LVL_B = 4,
   parameter int LVL_C = 8,
   parameter int LVL_D = 14
) (
   input  rxq_cfg_t        cfg_i,
   input  logic [CW-1:0]   count_i,
   output logic            trig_o
);

   if (LVL_A < 1 || LVL_A > DEPTH || LVL_B < 1 || LVL_B > DEPTH ||
       LVL_C < 1 || LVL_C > DEPTH || LVL_D < 1 || LVL_D > DEPTH) begin : g_bad_lvl
      $error("uart_rxq_trig: threshold outside 1..DEPTH");
   end

   logic [CW-1:0] thr;

   always_comb begin
      if (!cfg_i.en) begin
         thr = CW'(1);
      end else begin
         unique case (cfg_i.sel)
            TRIG_SEL_A: thr = CW'(LVL_A);
            TRIG_SEL_B: thr = CW'(LVL_B);
            TRIG_SEL_C: thr = CW'(LVL_C);
            default:    thr = CW'(LVL_D);
         endcase
      end
   end

   assign trig_o = (count_i >= thr);

endmodule

// File: rtl/uart_rxq_store.sv
module uart_rxq_store #(
   parameter int WIDTH       = 8,
   parameter int DEPTH       = 16,
   parameter int CW          = 5,
   parameter bit RESET_STORE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [WIDTH-1:0] push_data_i,
   input  logic             pop_i,
   input  logic             flush_i,
   input  logic             single_i,
   output logic [WIDTH-1:0] rd_data_o,
   output logic [CW-1:0]    count_o,
   output logic             empty_o,
   output logic             full_o,
   output logic             overrun_o
);

   localparam int AW = $clog2(DEPTH);

   logic [AW-1:0]    rptr_q, wptr_q;
   logic [CW-1:0]    cnt_q, cap;
   logic [WIDTH-1:0] hold_q;
   logic             ovr_q, push_ok, pop_ok, drop;
   logic [WIDTH-1:0] ent [DEPTH];

   assign cap     = single_i ? CW'(1) : CW'(DEPTH);
   assign empty_o = (cnt_q == '0);
   assign full_o  = (cnt_q >= cap);
   assign pop_ok  = pop_i & ~empty_o & ~flush_i;
   assign push_ok = push_i & ~flush_i & (~full_o | pop_ok);
   assign drop    = push_i & ~flush_i & full_o & ~pop_ok;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [WIDTH-1:0] q;
      logic             wen;
      assign wen    = push_ok && (wptr_q == AW'(i));
      assign ent[i] = q;
      if (RESET_STORE) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (wen) q <= push_data_i;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (wen) q <= push_data_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr_q <= '0;
         wptr_q <= '0;
         cnt_q  <= '0;
         ovr_q  <= 1'b0;
         hold_q <= '0;
      end else if (flush_i) begin
         rptr_q <= '0;
         wptr_q <= '0;
         cnt_q  <= '0;
         ovr_q  <= 1'b0;
      end else begin
         if (push_ok) wptr_q <= wptr_q + AW'(1);
         if (pop_ok) begin
            rptr_q <= rptr_q + AW'(1);
            hold_q <= ent[rptr_q];
         end
         cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
         if (drop) ovr_q <= 1'b1;
      end
   end

   assign rd_data_o = empty_o ? hold_q : ent[rptr_q];
   assign count_o   = cnt_q;
   assign overrun_o = ovr_q;

   // R3: a flush leaves nothing stored and no overrun
   assert_flush_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (count_o == '0) && !overrun_o);
   // R6: overrun only clears through a flush
   assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun_o && !flush_i) |=> overrun_o);
   // R6: a lone push into a full queue changes nothing but the flag
   assert_full_push_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && full_o && !pop_i && !flush_i) |=> overrun_o && $stable(count_o) && $stable(rd_data_o));
   // R7: a pop on an empty queue keeps the count and the shown byte
   assert_pop_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && empty_o && !push_i && !flush_i) |=> empty_o && $stable(rd_data_o));
   // R5: the count never passes the storage depth
   assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      count_o <= CW'(DEPTH));

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
   import uart_rxq_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int DEPTH       = 16,
   parameter int LVL_A       = 1,
   parameter int LVL_B       = 4,
   parameter int LVL_C       = 8,
   parameter int LVL_D       = 14,
   parameter bit RESET_STORE = 1'b0,
   localparam int CW         = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [WIDTH-1:0] push_data_i,
   input  logic             pop_i,
   input  logic             cfg_we_i,
   input  logic [7:0]       cfg_wdata_i,
   output logic [WIDTH-1:0] rd_data_o,
   output logic             empty_o,
   output logic             full_o,
   output logic [CW-1:0]    count_o,
   output logic             trig_o,
   output logic             overrun_o
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("uart_rxq: DEPTH must be a power of two of at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("uart_rxq: WIDTH must be positive");
   end

   rxq_cfg_t cfg;
   logic     flush;

   uart_rxq_ctl u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (cfg_we_i),
      .wdata_i (cfg_wdata_i),
      .cfg_o   (cfg),
      .flush_o (flush)
   );

   uart_rxq_store #(
      .WIDTH       (WIDTH),
      .DEPTH       (DEPTH),
      .CW          (CW),
      .RESET_STORE (RESET_STORE)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push_i),
      .push_data_i (push_data_i),
      .pop_i       (pop_i),
      .flush_i     (flush),
      .single_i    (~cfg.en),
      .rd_data_o   (rd_data_o),
      .count_o     (count_o),
      .empty_o     (empty_o),
      .full_o      (full_o),
      .overrun_o   (overrun_o)
   );

   uart_rxq_trig #(
      .DEPTH (DEPTH),
      .CW    (CW),
      .LVL_A (LVL_A),
      .LVL_B (LVL_B),
      .LVL_C (LVL_C),
      .LVL_D (LVL_D)
   ) u_trig (
      .cfg_i   (cfg),
      .count_i (count_o),
      .trig_o  (trig_o)
   );

   // R8: with queuing off at most one byte is held
   assert_single_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.en |-> (count_o <= CW'(1)));
   // R8: with queuing off the trigger follows any stored byte
   assert_disabled_trig_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.en |-> (trig_o == !empty_o));
   // R9: a write that flips the enable bit empties the queue
   assert_toggle_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we_i && (cfg_wdata_i[0] != cfg.en)) |=> empty_o);

endmodule

// File: tb/test_uart_rxq.sv
`timescale 1ns/1ps
module test_uart_rxq;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       push, pop, we;
   logic [7:0] pdata, cfg;
   logic [7:0] rd_data;
   logic       empty, full, trig, ovr;
   logic [4:0] count;

   always #2 clk = ~clk;

   uart_rxq #(.RESET_STORE(1'b1)) i_uart_rxq (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push),
      .push_data_i (pdata),
      .pop_i       (pop),
      .cfg_we_i    (we),
      .cfg_wdata_i (cfg),
      .rd_data_o   (rd_data),
      .empty_o     (empty),
      .full_o      (full),
      .count_o     (count),
      .trig_o      (trig),
      .overrun_o   (ovr)
   );

   typedef struct packed {
      logic       push;
      logic [7:0] d;
      logic       pop;
      logic       we;
      logic [7:0] cfg;
      logic [4:0] cnt;
      logic       trig;
      logic       empty;
      logic       full;
      logic       ovr;
      logic [7:0] data;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 8'h00, 1'b0, 1'b1, 8'h01, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
      '{1'b1, 8'hA1, 1'b0, 1'b0, 8'h00, 5'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA1},
      '{1'b0, 8'h00, 1'b0, 1'b1, 8'h41, 5'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA1},
      '{1'b1, 8'hA2, 1'b0, 1'b0, 8'h00, 5'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA1},
      '{1'b1, 8'hA3, 1'b0, 1'b0, 8'h00, 5'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA1},
      '{1'b1, 8'hA4, 1'b0, 1'b0, 8'h00, 5'd4, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA1},
      '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 5'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA2},
      '{1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hA1},
      '{1'b1, 8'hB1, 1'b0, 1'b0, 8'h00, 5'd1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hB1},
      '{1'b1, 8'hB2, 1'b0, 1'b0, 8'h00, 5'd1, 1'b1, 1'b0, 1'b1, 1'b1, 8'hB1},
      '{1'b0, 8'h00, 1'b0, 1'b1, 8'h02, 5'd1, 1'b1, 1'b0, 1'b1, 1'b1, 8'hB1},
      '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 5'd0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hB1},
      '{1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 5'd0, 1'b0, 1'b1, 1'b0, 1'b1, 8'hB1},
      '{1'b0, 8'h00, 1'b0, 1'b1, 8'h03, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hB1},
      '{1'b1, 8'hC1, 1'b0, 1'b1, 8'hC3, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hB1}
   };

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;
   logic [7:0] model [$];

   function automatic string vec_tag(int i);
      case (i)
         0:       return "R9";
         1, 2, 3, 4, 5: return "R4";
         6:       return "R10";
         7:       return "R9";
         8:       return "R8";
         9:       return "R6";
         10:      return "R2";
         11, 12:  return "R7";
         default: return "R3";
      endcase
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // called at a falling edge; applies one cycle of stimulus and returns at the next falling edge
   task automatic drive(bit pu, logic [7:0] d, bit po, bit w, logic [7:0] c);
      push = pu; pdata = d; pop = po; we = w; cfg = c;
      @(negedge clk);
      push = 1'b0; pop = 1'b0; we = 1'b0; pdata = 8'h00; cfg = 8'h00;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      push = 1'b0; pop = 1'b0; we = 1'b0; pdata = 8'h00; cfg = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "count", count, 0);
      chk("R1", "empty", empty, 1);
      chk("R1", "full",  full,  0);
      chk("R1", "trig",  trig,  0);
      chk("R1", "ovr",   ovr,   0);
      chk("R1", "data",  rd_data, 0);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i].push, VEC[i].d, VEC[i].pop, VEC[i].we, VEC[i].cfg);
         chk(vec_tag(i), $sformatf("v%0d count", i), count,   VEC[i].cnt);
         chk(vec_tag(i), $sformatf("v%0d trig",  i), trig,    VEC[i].trig);
         chk(vec_tag(i), $sformatf("v%0d empty", i), empty,   VEC[i].empty);
         chk(vec_tag(i), $sformatf("v%0d full",  i), full,    VEC[i].full);
         chk(vec_tag(i), $sformatf("v%0d ovr",   i), ovr,     VEC[i].ovr);
         chk(vec_tag(i), $sformatf("v%0d data",  i), rd_data, VEC[i].data);
      end

      // queue is on, threshold 14, empty: fill to the top (R4, R5)
      for (int k = 0; k < 16; k++) begin
         drive(1'b1, 8'h40 + 8'(k), 1'b0, 1'b0, 8'h00);
         model.push_back(8'h40 + 8'(k));
         chk("R4", $sformatf("trig at %0d", k + 1), trig, (k + 1 >= 14) ? 1 : 0);
      end
      chk("R5", "full at 16", full, 1);
      chk("R5", "count at 16", count, 16);
      chk("R10", "head when full", rd_data, 8'h40);

      // R6: lone push into full queue
      drive(1'b1, 8'hEE, 1'b0, 1'b0, 8'h00);
      chk("R6", "count after drop", count, 16);
      chk("R6", "overrun set", ovr, 1);
      chk("R6", "head after drop", rd_data, 8'h40);

      // R6: push with pop while full is taken
      drive(1'b1, 8'h77, 1'b1, 1'b0, 8'h00);
      void'(model.pop_front());
      model.push_back(8'h77);
      chk("R6", "count push+pop full", count, 16);
      chk("R6", "head push+pop full", rd_data, 8'h41);
      chk("R6", "overrun sticky", ovr, 1);

      // R5 / R10: drain in arrival order
      for (int k = 0; k < 16; k++) begin
         chk("R10", $sformatf("drain head %0d", k), rd_data, model[0]);
         drive(1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
         void'(model.pop_front());
      end
      chk("R5", "empty after drain", empty, 1);
      drive(1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
      chk("R7", "count pop empty", count, 0);
      chk("R7", "data pop empty", rd_data, 8'h77);

      // R3 / R4: flush and threshold 8
      drive(1'b0, 8'h00, 1'b0, 1'b1, 8'h83);
      chk("R3", "overrun cleared", ovr, 0);
      for (int k = 0; k < 8; k++) begin
         drive(1'b1, 8'h10 + 8'(k), 1'b0, 1'b0, 8'h00);
         chk("R4", $sformatf("lvl8 trig at %0d", k + 1), trig, (k == 7) ? 1 : 0);
      end
      drive(1'b0, 8'h00, 1'b1, 1'b0, 8'h00);
      chk("R4", "lvl8 trig at 7", trig, 0);
      // R4: switch to threshold 4 without flushing
      drive(1'b0, 8'h00, 1'b0, 1'b1, 8'h41);
      chk("R3", "no flush with bit1 clear", count, 7);
      chk("R4", "lvl4 trig at 7", trig, 1);
      // R9: turning queuing off empties
      drive(1'b0, 8'h00, 1'b0, 1'b1, 8'h40);
      chk("R9", "count after disable", count, 0);
      chk("R9", "empty after disable", empty, 1);

      // R1: reset in the middle of traffic
      drive(1'b1, 8'h5A, 1'b0, 1'b0, 8'h00);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "count after reset", count, 0);
      chk("R1", "empty after reset", empty, 1);
      chk("R1", "data after reset", rd_data, 0);
      drive(1'b1, 8'h33, 1'b0, 1'b0, 8'h00);
      chk("R8", "disabled trig after reset", trig, 1);
      chk("R8", "disabled full after reset", full, 1);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule